// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block sits between a cache and a DRAM device and turns whole-line requests into a timed stream of device commands. Every request moves one 64-byte line. The request address is split into a row, a bank and a column. Each of the banks keeps the row it last opened until something forces that row closed. A request to that same row goes straight to column accesses. A request to a bank with nothing open first opens the row. A request to a bank holding a different row closes that row, then opens the new one, then starts the column accesses.

Each line moves as eight column commands on consecutive cycles. The commands walk upward from the line's first column. Read data beats are flagged a fixed latency after each read command. Write data is requested in the same cycle as each write command. A free-running interval timer requests refresh. The sequencer first finishes the line in progress, then closes every open bank in ascending bank order, then issues the refresh command. While the refresh recovers, no requests are taken. Only one request is in flight at a time, and the request port's ready signal shows when the next one may enter.

Top module: `dram_cmd_seq`

## Requirements
- R1: The request address is {row[22:11], bank[10:9], column[8:0]}. An activate command (code 1) carries the row on `cmd_addr`, and every command names its bank on `cmd_bank`.
- R2: A request to the row already open in its bank is a hit. It issues only column commands (read code 2, write code 3), with no activate and no precharge.
- R3: A request to a bank with no open row issues an activate for the requested row. The first column command follows exactly T_RCD cycles after the activate.
- R4: A request to a bank holding a different row issues a precharge (code 4) to that bank, then an activate exactly T_RP cycles later, then the column commands. An activate is never issued to a bank that already has an open row.
- R5: A precharge to a bank is never issued sooner than T_RAS cycles after the last activate to that bank. The sequencer holds the precharge until this is satisfied.
- R6: Each line is eight column commands on eight consecutive cycles. The column address starts at the request's column with its three low bits forced to zero and rises by one per command. The request's three low column bits have no effect.
- R7: Each read command is followed, exactly T_CL cycles later, by one pulse of `rd_data_valid`. Each write command is accompanied in the same cycle by one pulse of `wr_data_strobe`.
- R8: When T_REFI cycles of the refresh interval have elapsed, the sequencer finishes the current line. It then precharges every open bank in ascending bank order, with consecutive precharges T_RP cycles apart, and issues a refresh (code 5) T_RP cycles after the last precharge. After the refresh, every bank counts as having no open row.
- R9: `req_ready` is low during a line burst, during a pending refresh and for T_RFC cycles after a refresh command. A request held valid across a refresh produces its first command T_RFC+1 cycles after the refresh.
- R10: While reset is asserted and right after it is released, `cmd` is the idle code 0, `req_ready` is high, and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A line request is presented |
| req_ready | output | 1 | The sequencer takes the request on this edge |
| req_write | input | 1 | 1 for a line write, 0 for a line read |
| req_addr | input | 23 | Request address: row, bank, column |
| cmd | output | 3 | Command code: 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh |
| cmd_bank | output | 2 | Bank the command targets |
| cmd_addr | output | 12 | Row for activate, column for read and write, zero otherwise |
| rd_data_valid | output | 1 | A read data beat is on the data bus |
| wr_data_strobe | output | 1 | A write data beat must be driven this cycle |

## Verification
The bench builds the sequencer with T_RCD=3, T_RP=2, T_CL=4 and T_RFC=6, so every gap is short and can be measured exactly. T_RAS is 20. That is longer than one empty-bank line plus the read latency, so a conflict right after an activate must visibly wait on the row-active limit. T_REFI is 1000. This keeps the table of hit, empty and conflict cases clear of refresh. It also lets the bench time a line request so that the refresh interval expires in the middle of the burst, with a second request held waiting behind it.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } dram_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_WAIT,
    ST_RPRE
  } seq_state_e;

  typedef enum logic [1:0] {
    CLS_HIT      = 2'd0,
    CLS_EMPTY    = 2'd1,
    CLS_CONFLICT = 2'd2
  } row_class_e;

endpackage

// File: rtl/dram_addr_map.sv
module dram_addr_map
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int BEAT_W = 3,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W,
  localparam int NBANK  = 1 << BANK_W,
  localparam int LCOL_W = COL_W - BEAT_W
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NBANK-1:0]             open_vec,
  input  logic [NBANK-1:0][ROW_W-1:0]  open_rows,
  output logic [ROW_W-1:0]             row,
  output logic [BANK_W-1:0]            bank,
  output logic [LCOL_W-1:0]            line_col,
  output row_class_e                   cls
);

  always_comb begin
    row      = addr[ADDR_W-1 -: ROW_W];
    bank     = addr[COL_W +: BANK_W];
    line_col = addr[BEAT_W +: LCOL_W];
    if (!open_vec[bank]) begin
      cls = CLS_EMPTY;
    end else if (open_rows[bank] == row) begin
      cls = CLS_HIT;
    end else begin
      cls = CLS_CONFLICT;
    end
  end

endmodule

// File: rtl/dram_bank_table.sv
module dram_bank_table #(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int T_RAS  = 8,
  localparam int NBANK = 1 << BANK_W,
  localparam int RAS_W = $clog2(T_RAS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         act_en,
  input  logic [BANK_W-1:0]            act_bank,
  input  logic [ROW_W-1:0]             act_row,
  input  logic                         pre_en,
  input  logic [BANK_W-1:0]            pre_bank,
  input  logic                         ref_en,
  output logic [NBANK-1:0]             open_vec,
  output logic [NBANK-1:0][ROW_W-1:0]  open_rows,
  output logic [NBANK-1:0]             ras_ok
);

  localparam logic [RAS_W-1:0] RAS_LOAD = RAS_W'(T_RAS - 1);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic             open_q;
    logic             open_d;
    logic [ROW_W-1:0] row_q;
    logic [RAS_W-1:0] ras_q;
    logic [RAS_W-1:0] ras_d;
    logic             act_hit;
    logic             pre_hit;

    assign act_hit = act_en && (act_bank == BANK_W'(g));
    assign pre_hit = pre_en && (pre_bank == BANK_W'(g));

    always_comb begin
      open_d = open_q;
      if (ref_en) begin
        open_d = 1'b0;
      end else if (act_hit) begin
        open_d = 1'b1;
      end else if (pre_hit) begin
        open_d = 1'b0;
      end
      ras_d = ras_q;
      if (act_hit) begin
        ras_d = RAS_LOAD;
      end else if (ras_q != '0) begin
        ras_d = ras_q - RAS_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        ras_q  <= '0;
      end else begin
        open_q <= open_d;
        ras_q  <= ras_d;
      end
    end

    always_ff @(posedge clk) begin
      if (act_hit) begin
        row_q <= act_row;
      end
    end

    assign open_vec[g]  = open_q;
    assign open_rows[g] = row_q;
    assign ras_ok[g]    = (ras_q == '0);

    // R4: a bank is opened only after it has been closed
    assert_act_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      act_hit |-> !open_q);

    // R5: closing a bank respects the row-active minimum
    assert_pre_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pre_hit |-> (ras_q == '0));
  end

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int T_REFI = 3120,
  localparam int CNT_W = $clog2(T_REFI)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pending
);

  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(T_REFI - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;

  always_comb begin
    cnt_d  = cnt_q - CNT_W'(1);
    pend_d = pend_q;
    if (ack) begin
      pend_d = 1'b0;
    end
    if (cnt_q == '0) begin
      cnt_d  = CNT_LOAD;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_LOAD;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;

  // R8: a refresh is only issued while one is owed
  assert_ack_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pend_q);

endmodule

// File: rtl/dram_rd_pipe.sv
module dram_rd_pipe #(
  parameter int T_CL = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_issue,
  output logic rd_beat
);

  logic [T_CL-1:0] sh_q;
  logic [T_CL-1:0] sh_d;

  if (T_CL == 1) begin : g_one
    assign sh_d = rd_issue;
  end else begin : g_many
    assign sh_d = {sh_q[T_CL-2:0], rd_issue};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rd_beat = sh_q[T_CL-1];

endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int BEAT_W = 3,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_RAS  = 8,
  parameter int T_CL   = 5,
  parameter int T_RFC  = 20,
  parameter int T_REFI = 3120,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W,
  localparam int CA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [CA_W-1:0]   cmd_addr,
  output logic              rd_data_valid,
  output logic              wr_data_strobe
);

  localparam int NBANK  = 1 << BANK_W;
  localparam int LCOL_W = COL_W - BEAT_W;
  localparam int LDLY0  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int LDLY   = (LDLY0 > T_RFC) ? LDLY0 : T_RFC;
  localparam int WC_W   = $clog2(LDLY + 1);
  localparam logic [BEAT_W-1:0] BEAT_LAST = '1;

  seq_state_e        state_q, state_d;
  seq_state_e        ret_q, ret_d;
  logic [WC_W-1:0]   wcnt_q, wcnt_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              wr_q;
  logic [ROW_W-1:0]  row_q;
  logic [BANK_W-1:0] bank_q;
  logic [LCOL_W-1:0] lcol_q;

  logic [NBANK-1:0]            open_vec;
  logic [NBANK-1:0][ROW_W-1:0] open_rows;
  logic [NBANK-1:0]            ras_ok;
  logic [ROW_W-1:0]            in_row;
  logic [BANK_W-1:0]           in_bank;
  logic [LCOL_W-1:0]           in_lcol;
  row_class_e                  in_cls;
  logic                        ref_pend;
  logic                        any_open;
  logic [BANK_W-1:0]           low_bank;

  dram_cmd_e         cmd_c;
  logic [BANK_W-1:0] bank_c;
  logic [CA_W-1:0]   addr_c;
  logic              accept;
  logic              act_en, pre_en, ref_en;
  logic [BANK_W-1:0] pre_bank;

  dram_addr_map #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .BEAT_W(BEAT_W)
  ) u_map (
    .addr(req_addr), .open_vec(open_vec), .open_rows(open_rows),
    .row(in_row), .bank(in_bank), .line_col(in_lcol), .cls(in_cls)
  );

  dram_bank_table #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .T_RAS(T_RAS)
  ) u_banks (
    .clk(clk), .rst_n(rst_n),
    .act_en(act_en), .act_bank(bank_q), .act_row(row_q),
    .pre_en(pre_en), .pre_bank(pre_bank), .ref_en(ref_en),
    .open_vec(open_vec), .open_rows(open_rows), .ras_ok(ras_ok)
  );

  dram_refresh_timer #(.T_REFI(T_REFI)) u_refi (
    .clk(clk), .rst_n(rst_n), .ack(ref_en), .pending(ref_pend)
  );

  dram_rd_pipe #(.T_CL(T_CL)) u_rdp (
    .clk(clk), .rst_n(rst_n), .rd_issue(cmd_c == CMD_RD), .rd_beat(rd_data_valid)
  );

  // lowest-numbered open bank is closed first during refresh
  always_comb begin
    any_open = |open_vec;
    low_bank = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (open_vec[i]) begin
        low_bank = BANK_W'(i);
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE) && !ref_pend;
  assign accept    = req_ready && req_valid;

  always_comb begin
    state_d  = state_q;
    ret_d    = ret_q;
    wcnt_d   = wcnt_q;
    beat_d   = beat_q;
    cmd_c    = CMD_NOP;
    bank_c   = bank_q;
    addr_c   = '0;
    act_en   = 1'b0;
    pre_en   = 1'b0;
    ref_en   = 1'b0;
    pre_bank = bank_q;
    unique case (state_q)
      ST_IDLE: begin
        beat_d = '0;
        if (ref_pend) begin
          state_d = ST_RPRE;
        end else if (req_valid) begin
          unique case (in_cls)
            CLS_HIT:   state_d = ST_COL;
            CLS_EMPTY: state_d = ST_ACT;
            default:   state_d = ST_PRE;
          endcase
        end
      end
      ST_PRE: begin
        if (ras_ok[bank_q]) begin
          cmd_c  = CMD_PRE;
          pre_en = 1'b1;
          if (T_RP == 1) begin
            state_d = ST_ACT;
          end else begin
            state_d = ST_WAIT;
            ret_d   = ST_ACT;
            wcnt_d  = WC_W'(T_RP - 1);
          end
        end
      end
      ST_ACT: begin
        cmd_c  = CMD_ACT;
        addr_c = CA_W'(row_q);
        act_en = 1'b1;
        if (T_RCD == 1) begin
          state_d = ST_COL;
        end else begin
          state_d = ST_WAIT;
          ret_d   = ST_COL;
          wcnt_d  = WC_W'(T_RCD - 1);
        end
      end
      ST_COL: begin
        cmd_c  = wr_q ? CMD_WR : CMD_RD;
        addr_c = CA_W'({lcol_q, beat_q});
        beat_d = beat_q + BEAT_W'(1);
        if (beat_q == BEAT_LAST) begin
          state_d = ST_IDLE;
        end
      end
      ST_WAIT: begin
        wcnt_d = wcnt_q - WC_W'(1);
        if (wcnt_q == WC_W'(1)) begin
          state_d = ret_q;
        end
      end
      ST_RPRE: begin
        if (any_open) begin
          bank_c   = low_bank;
          pre_bank = low_bank;
          if (ras_ok[low_bank]) begin
            cmd_c  = CMD_PRE;
            pre_en = 1'b1;
            if (T_RP > 1) begin
              state_d = ST_WAIT;
              ret_d   = ST_RPRE;
              wcnt_d  = WC_W'(T_RP - 1);
            end
          end
        end else begin
          cmd_c  = CMD_REF;
          bank_c = '0;
          ref_en = 1'b1;
          if (T_RFC == 1) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_WAIT;
            ret_d   = ST_IDLE;
            wcnt_d  = WC_W'(T_RFC - 1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_IDLE;
      wcnt_q  <= '0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      wcnt_q  <= wcnt_d;
      beat_q  <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      wr_q   <= req_write;
      row_q  <= in_row;
      bank_q <= in_bank;
      lcol_q <= in_lcol;
    end
  end

  assign cmd            = cmd_c;
  assign cmd_bank       = bank_c;
  assign cmd_addr       = addr_c;
  assign wr_data_strobe = (cmd_c == CMD_WR);

  // R6: column commands of one line follow back to back with rising columns
  assert_burst_contig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == 3'(CMD_RD) || cmd == 3'(CMD_WR)) && cmd_addr[BEAT_W-1:0] != BEAT_LAST)
    |=> (cmd == $past(cmd) && cmd_addr == $past(cmd_addr) + CA_W'(1)));

  // R8: refresh only once every bank has been closed
  assert_ref_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'(CMD_REF)) |-> (open_vec == '0));

  // R9: no request is taken while a line is moving
  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'(CMD_RD) || cmd == 3'(CMD_WR)) |-> !req_ready);

endmodule

// File: tb/tb_dram_cmd_seq.sv
module tb_dram_cmd_seq;

  localparam int T_RCD  = 3;
  localparam int T_RP   = 2;
  localparam int T_RAS  = 20;
  localparam int T_CL   = 4;
  localparam int T_RFC  = 6;
  localparam int T_REFI = 1000;

  localparam int HIT = 0, EMPTY = 1, CONF = 2;

  // {class[25:24], write[23], row[22:11], bank[10:9], col[8:0]}
  localparam logic [25:0] VEC [0:9] = '{
    {2'd1, 1'b0, 12'h005, 2'd0, 9'h010},
    {2'd0, 1'b0, 12'h005, 2'd0, 9'h018},
    {2'd0, 1'b1, 12'h005, 2'd0, 9'h1F8},
    {2'd1, 1'b0, 12'h123, 2'd1, 9'h000},
    {2'd2, 1'b1, 12'h007, 2'd0, 9'h040},
    {2'd0, 1'b0, 12'h123, 2'd1, 9'h007},
    {2'd1, 1'b0, 12'hFFF, 2'd3, 9'h100},
    {2'd2, 1'b1, 12'h000, 2'd3, 9'h0A8},
    {2'd1, 1'b0, 12'h001, 2'd2, 9'h1C0},
    {2'd0, 1'b0, 12'h007, 2'd0, 9'h048}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [2:0]  cmd;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_addr;
  logic        rd_data_valid;
  logic        wr_data_strobe;

  always #5 clk = ~clk;

  dram_cmd_seq #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_CL(T_CL),
    .T_RFC(T_RFC), .T_REFI(T_REFI)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .cmd(cmd), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .rd_data_valid(rd_data_valid), .wr_data_strobe(wr_data_strobe)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [2:0]  lg_cmd  [0:511];
  logic [1:0]  lg_bank [0:511];
  logic [11:0] lg_addr [0:511];
  int          lg_cyc  [0:511];
  int          log_n = 0;
  int          dv_cyc  [0:1023];
  int          dv_n = 0;
  int          wr_cyc  [0:1023];
  int          wr_n = 0;
  int          last_act [0:3];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd != 3'd0 && log_n < 512) begin
        lg_cmd[log_n]  = cmd;
        lg_bank[log_n] = cmd_bank;
        lg_addr[log_n] = cmd_addr;
        lg_cyc[log_n]  = cyc;
        log_n++;
      end
      if (rd_data_valid && dv_n < 1024) begin
        dv_cyc[dv_n] = cyc;
        dv_n++;
      end
      if (wr_data_strobe && wr_n < 1024) begin
        wr_cyc[wr_n] = cyc;
        wr_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_line(input int s, input bit w, input logic [11:0] row,
                            input logic [1:0] bank, input logic [8:0] col,
                            input int cls, input int ds, input int ws, output int p_end);
    int p = s;
    int a;
    bit ok;
    if (cls == CONF) begin
      chk(lg_cmd[p] == 3'd4 && lg_bank[p] == bank, "R4 precharge opens conflict", int'(lg_cmd[p]), 4);
      chk(lg_cyc[p] - last_act[bank] >= T_RAS, "R5 row active minimum", lg_cyc[p] - last_act[bank], T_RAS);
      chk(lg_cyc[p+1] - lg_cyc[p] == T_RP, "R4 precharge to activate gap", lg_cyc[p+1] - lg_cyc[p], T_RP);
      p++;
    end
    if (cls != HIT) begin
      chk(lg_cmd[p] == 3'd1 && lg_bank[p] == bank && lg_addr[p] == row,
          "R1 activate carries row and bank", int'(lg_addr[p]), int'(row));
      a = p;
      last_act[bank] = lg_cyc[a];
      p++;
      chk(lg_cyc[p] - lg_cyc[a] == T_RCD, "R3 activate to column gap", lg_cyc[p] - lg_cyc[a], T_RCD);
    end else begin
      chk(lg_cmd[p] == (w ? 3'd3 : 3'd2), "R2 hit starts with column", int'(lg_cmd[p]), w ? 3 : 2);
    end
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (lg_cmd[p+i] != (w ? 3'd3 : 3'd2) || lg_bank[p+i] != bank ||
          lg_addr[p+i] != {3'b000, col[8:3], 3'(i)} || lg_cyc[p+i] != lg_cyc[p] + i)
        ok = 1'b0;
    end
    chk(ok, "R6 eight rising columns back to back", int'(lg_addr[p]), int'({3'b000, col[8:3], 3'b000}));
    if (!w) begin
      chk(dv_n - ds >= 8 && dv_cyc[ds] == lg_cyc[p] + T_CL && dv_cyc[ds+7] == lg_cyc[p] + 7 + T_CL,
          "R7 read beats after latency", dv_cyc[ds], lg_cyc[p] + T_CL);
    end else begin
      chk(wr_n - ws >= 8 && wr_cyc[ws] == lg_cyc[p] && wr_cyc[ws+7] == lg_cyc[p] + 7,
          "R7 write strobes with commands", wr_cyc[ws], lg_cyc[p]);
    end
    p_end = p + 8;
  endtask

  task automatic present(input bit w, input logic [11:0] row, input logic [1:0] bank,
                         input logic [8:0] col);
    req_write = w;
    req_addr  = {row, bank, col};
    req_valid = 1'b1;
  endtask

  task automatic wait_log(input int n);
    while (log_n < n) begin
      @(negedge clk);
      #1;
    end
    repeat (T_CL + 2) @(negedge clk);
    #1;
  endtask

  initial begin
    int s, ds, ws, pe, p, cls;
    bit ok;
    for (int b = 0; b < 4; b++) last_act[b] = -1000;
    repeat (3) @(negedge clk);
    chk(cmd == 3'd0 && req_ready && !rd_data_valid && !wr_data_strobe,
        "R10 outputs during reset", int'(cmd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(cmd == 3'd0 && req_ready && !rd_data_valid && !wr_data_strobe,
        "R10 outputs after reset", int'(req_ready), 1);

    for (int v = 0; v < 10; v++) begin
      cls = int'(VEC[v][25:24]);
      present(VEC[v][23], VEC[v][22:11], VEC[v][10:9], VEC[v][8:0]);
      while (!req_ready) begin
        @(negedge clk);
        #1;
      end
      s = log_n; ds = dv_n; ws = wr_n;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      wait_log(s + 8 + (cls == HIT ? 0 : (cls == EMPTY ? 1 : 2)));
      check_line(s, VEC[v][23], VEC[v][22:11], VEC[v][10:9], VEC[v][8:0], cls, ds, ws, pe);
    end

    // refresh arriving mid-line with a second request held waiting (R8, R9)
    while (cyc < T_REFI - 6) begin
      @(negedge clk);
      #1;
    end
    present(1'b0, 12'h007, 2'd0, 9'h040);
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    s = log_n; ds = dv_n; ws = wr_n;
    @(posedge clk);
    #1;
    present(1'b0, 12'h123, 2'd1, 9'h080);
    @(negedge clk);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    wait_log(s + 8 + 4 + 1 + 9);
    check_line(s, 1'b0, 12'h007, 2'd0, 9'h040, HIT, ds, ws, pe);
    p = pe;
    ok = 1'b1;
    for (int b = 0; b < 4; b++) begin
      if (lg_cmd[p+b] != 3'd4 || lg_bank[p+b] != 2'(b)) ok = 1'b0;
      if (b > 0 && lg_cyc[p+b] - lg_cyc[p+b-1] != T_RP) ok = 1'b0;
    end
    chk(ok, "R8 precharge all open banks in order", int'(lg_bank[p]), 0);
    chk(lg_cyc[p] > lg_cyc[p-1], "R8 line finishes before refresh", lg_cyc[p], lg_cyc[p-1] + 1);
    chk(lg_cmd[p+4] == 3'd5 && lg_cyc[p+4] - lg_cyc[p+3] == T_RP,
        "R8 refresh after last precharge", lg_cyc[p+4] - lg_cyc[p+3], T_RP);
    chk(lg_cmd[p+5] == 3'd1 && lg_cyc[p+5] - lg_cyc[p+4] == T_RFC + 1,
        "R9 held request waits out recovery", lg_cyc[p+5] - lg_cyc[p+4], T_RFC + 1);
    check_line(p + 5, 1'b0, 12'h123, 2'd1, 9'h080, EMPTY, ds + 8, ws, pe);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule